// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a three-wire serial EEPROM. It has a chip select, a serial clock, a data input, and a data output with an output enable. The storage array is held in registers. It is organised as 128 bytes or as 64 sixteen-bit words, selected by a parameter. A host raises chip select and shifts in a start bit, a two-bit opcode and an address field. For a write, the data word follows. The block then reads, writes or erases one location, writes or erases the whole array, or sets or clears its write-enable latch.

Programming is self-timed. A fixed number of system clock cycles passes before the new contents land in the array. During that time the host can poll for completion. It does this by dropping chip select for a minimum time and raising it again. The data output then reports busy or ready.

The serial pins are sampled by the system clock `clk`. A serial clock edge is acted on in the system cycle where it is first seen high.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, every location reads as all ones, the write-enable latch is off, and `sdo_en` is low.
- R2: Read uses opcode 10. In the system cycle after the `sclk` rise that samples the last address bit, `sdo_en` is 1 and `sdo` is 0, which is the dummy bit. Each following rise presents the next data bit, most significant first.
- R3: Opcode 00 with address MSBs 11 turns the write-enable latch on. Opcode 00 with address MSBs 00 turns it off. The remaining address bits are don't-care but must still be clocked.
- R4: Write uses opcode 01. It takes the data word after the address. Programming starts after the last data bit, and the new value is readable after `PROG_CYCLES` cycles.
- R5: Erase uses opcode 11 and sets every bit of the addressed location to 1.
- R6: Opcode 00 with address MSBs 10 sets every location to all ones.
- R7: Opcode 00 with address MSBs 01 takes one data word and writes it to every location.
- R8: While the latch is off, write, erase, erase-all and write-all leave the array unchanged.
- R9: During programming, suppose chip select goes high after being low for at least `CS_LOW_MIN` cycles. Then `sdo_en` is 1 and `sdo` is 0 while busy, and `sdo` becomes 1 once programming completes. A shorter low time gives no status.
- R10: Dropping chip select before an instruction is complete aborts it with no array change.
- R11: While chip select is low, `sdo_en` and `sdo` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first, sampled on `sclk` rise |
| sdo | output | 1 | Serial data out: read data or ready/busy |
| sdo_en | output | 1 | Output enable for `sdo` |

## Verification
The bench reads a location straight after reset to catch an array that does not start erased. It checks the dummy zero in front of read data, because a missing dummy shifts every data bit by one place.

It tries a write before the enable instruction, and again after the disable instruction. A latch that gates wrongly would let either write corrupt the array.

It cuts chip select halfway through a data word. It also polls status with a low pulse that is too short and then with one that is long enough. A design that committed partial words, or reported status on every toggle, would fail these checks.

Whole-array erase and write are each followed by reads of the first and last locations. This catches a loop bound that stops short of the ends of the array.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter bit WORD16      = 1'b0,
  parameter int PROG_CYCLES = 2000,
  parameter int CS_LOW_MIN  = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int DW    = WORD16 ? 16 : 8;
  localparam int AW    = WORD16 ? 6 : 7;
  localparam int DEPTH = 1 << AW;
  localparam int HW    = AW + 2;
  localparam int CW    = $clog2(HW + DW + 1);
  localparam int PCW   = $clog2(PROG_CYCLES + 1);
  localparam int LCW   = $clog2(CS_LOW_MIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RD, S_WD, S_PROG, S_HOLD} st_t;

  st_t            st;
  logic [DW-1:0]  mem [DEPTH];
  logic [HW-1:0]  hdr;
  logic [CW-1:0]  cnt;
  logic [DW:0]    rsh;
  logic [DW-1:0]  pdata;
  logic [AW-1:0]  paddr;
  logic           pall, wen, stat, cs_q, sk_q;
  logic [PCW-1:0] pcnt;
  logic [LCW-1:0] lowcnt;

  wire          sk_rise = sclk & ~sk_q;
  wire          cs_rise = cs & ~cs_q;
  wire [HW-1:0] hdr_n   = {hdr[HW-2:0], sdi};
  wire [1:0]    op      = hdr_n[HW-1:HW-2];
  wire [1:0]    ext     = hdr_n[AW-1:AW-2];
  wire [AW-1:0] addr    = hdr_n[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hdr    <= '0;
      cnt    <= '0;
      rsh    <= '0;
      pdata  <= '0;
      paddr  <= '0;
      pall   <= 1'b0;
      wen    <= 1'b0;
      stat   <= 1'b0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      pcnt   <= '0;
      lowcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      cs_q <= cs;
      sk_q <= sclk;
      if (!cs) begin
        if (lowcnt != LCW'(CS_LOW_MIN)) lowcnt <= lowcnt + 1'b1;
        stat <= 1'b0;
      end else begin
        lowcnt <= '0;
      end
      if (cs_rise && lowcnt == LCW'(CS_LOW_MIN) && st == S_PROG) stat <= 1'b1;

      if (st == S_PROG) begin
        if (pcnt == PCW'(PROG_CYCLES - 1)) begin
          pcnt <= '0;
          st   <= S_IDLE;
          if (pall) for (int i = 0; i < DEPTH; i++) mem[i] <= pdata;
          else mem[paddr] <= pdata;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end else if (!cs) begin
        st <= S_IDLE;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (sdi) begin
            st   <= S_HDR;
            cnt  <= '0;
            stat <= 1'b0;
          end
          S_HDR: begin
            hdr <= hdr_n;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              cnt   <= '0;
              paddr <= addr;
              pall  <= 1'b0;
              st    <= S_HOLD;
              case (op)
                2'b10: begin
                  rsh <= {1'b0, mem[addr]};
                  st  <= S_RD;
                end
                2'b01: st <= S_WD;
                2'b11: if (wen) begin
                  pdata <= '1;
                  st    <= S_PROG;
                end
                default: case (ext)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b10: begin
                    pall <= 1'b1;
                    if (wen) begin
                      pdata <= '1;
                      st    <= S_PROG;
                    end
                  end
                  default: begin
                    pall <= 1'b1;
                    st   <= S_WD;
                  end
                endcase
              endcase
            end
          end
          S_RD: rsh <= rsh << 1;
          S_WD: begin
            pdata <= {pdata[DW-2:0], sdi};
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) st <= wen ? S_PROG : S_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_en = cs & (stat | (st == S_RD));
  assign sdo    = cs & (stat ? (st != S_PROG) : ((st == S_RD) & rsh[DW]));

  p_dummy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && st == S_HDR && sk_rise && cnt == CW'(HW - 1) && op == 2'b10)
      |=> (!cs || (sdo_en && !sdo)));

  p_wen_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(st) == S_HDR);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && pcnt != PCW'(PROG_CYCLES - 1)) |=> st == S_PROG);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen && cs && st == S_WD && sk_rise && cnt == CW'(DW - 1)) |=> st != S_PROG);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && st != S_PROG) |=> st == S_IDLE);

  p_mem_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_PROG) |=> $stable(mem[0]));
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int PC = 300;
  localparam int CL = 20;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  mw_eeprom #(.WORD16(1'b0), .PROG_CYCLES(PC), .CS_LOW_MIN(CL)) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_on;
    @(negedge clk); cs = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off(input int n);
    @(negedge clk); cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output bit dummy_ok);
    cs_on();
    send(16'b110, 3);
    send(16'(a), AW);
    dummy_ok = sdo_en && !sdo;
    for (int i = DW - 1; i >= 0; i--) begin
      bit_out(1'b0);
      d[i] = sdo;
    end
    cs_off(CL + 5);
  endtask

  task automatic cmd00(input logic [1:0] e);
    cs_on();
    send(16'b100, 3);
    send(16'({e, 5'b0}), AW);
    cs_off(CL + 5);
  endtask

  task automatic poll_done(input string req);
    int n = 0;
    bit busy;
    cs_off(CL + 5);
    @(negedge clk); cs = 1'b1;
    repeat (2) @(negedge clk);
    busy = sdo_en && !sdo;
    check(busy, req, {sdo_en, sdo}, 2'b10);
    while (!sdo && n < PC + 50) begin
      @(negedge clk); n++;
    end
    check(sdo_en && sdo, req, {sdo_en, sdo}, 2'b11);
    cs_off(CL + 5);
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    logic [DW-1:0] d;
    bit dok;
    rd(a, d, dok);
    check(dok, "R2 dummy", 0, 0);
    check(d == e, req, d, e);
  endtask

  task automatic t_reset;
    check(!sdo_en && !sdo, "R1 sdo_en", {sdo_en, sdo}, 0);
    expect_rd(7'h05, 8'hFF, "R1 erased");
  endtask

  task automatic t_locked;
    cs_on(); send(16'b101, 3); send(16'h12, AW); send(16'h3C, DW); cs_off(PC + 20);
    expect_rd(7'h12, 8'hFF, "R8 write locked");
  endtask

  task automatic t_write;
    cmd00(2'b11);
    cs_on(); send(16'b101, 3); send(16'h12, AW); send(16'hA5, DW);
    poll_done("R9 status write");
    expect_rd(7'h12, 8'hA5, "R4 write");
    cs_on(); send(16'b101, 3); send(16'h7F, AW); send(16'h5A, DW);
    poll_done("R4 busy");
    expect_rd(7'h7F, 8'h5A, "R2 read");
  endtask

  task automatic t_short_low;
    cs_on(); send(16'b101, 3); send(16'h20, AW); send(16'h0F, DW);
    cs_off(3);
    @(negedge clk); cs = 1'b1; repeat (2) @(negedge clk);
    check(!sdo_en, "R9 short low", sdo_en, 0);
    poll_done("R9 long low");
    expect_rd(7'h20, 8'h0F, "R4 second");
  endtask

  task automatic t_erase;
    cs_on(); send(16'b111, 3); send(16'h12, AW);
    poll_done("R5 busy");
    expect_rd(7'h12, 8'hFF, "R5 erase");
    expect_rd(7'h20, 8'h0F, "R5 neighbour");
  endtask

  task automatic t_all;
    cs_on(); send(16'b100, 3); send(16'({2'b01, 5'b0}), AW); send(16'hC3, DW);
    poll_done("R7 busy");
    expect_rd(7'h00, 8'hC3, "R7 first");
    expect_rd(7'h7F, 8'hC3, "R7 last");
    cs_on(); send(16'b100, 3); send(16'({2'b10, 5'b0}), AW);
    poll_done("R6 busy");
    expect_rd(7'h00, 8'hFF, "R6 first");
    expect_rd(7'h7F, 8'hFF, "R6 last");
  endtask

  task automatic t_abort;
    cs_on(); send(16'b101, 3); send(16'h33, AW); send(16'h5, 4);
    cs_off(PC + 20);
    expect_rd(7'h33, 8'hFF, "R10 abort");
  endtask

  task automatic t_cs_low;
    cs_on(); send(16'b110, 3); send(16'h00, AW); bit_out(1'b0);
    @(negedge clk); cs = 1'b0; repeat (2) @(negedge clk);
    check(!sdo_en && !sdo, "R11 released", {sdo_en, sdo}, 0);
    cs_off(CL + 5);
  endtask

  task automatic t_disable;
    cmd00(2'b00);
    cs_on(); send(16'b101, 3); send(16'h40, AW); send(16'h11, DW); cs_off(PC + 20);
    expect_rd(7'h40, 8'hFF, "R3 disabled");
    cs_on(); send(16'b111, 3); send(16'h20, AW); cs_off(PC + 20);
    expect_rd(7'h20, 8'h0F, "R8 erase locked");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_locked();
    t_write();
    t_short_low();
    t_erase();
    t_abort();
    t_cs_low();
    t_disable();
    cmd00(2'b11);
    t_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule